// File: doc/BRIEF.md
# Condition Code Flag Register Unit

This block holds the 8-bit condition-code register of a small CPU that works on 16-bit and 32-bit data, and produces the arithmetic flags for add, subtract, compare and negate. Each operation can work on a byte, a word or a longword. The caller presents two operands, an operation code, a size select and an update-enable. When the enable is high, the register takes the half-carry, negative, zero, overflow and carry flags of that operation on the following clock edge.

Software reaches the register through a small command port. That port can load an immediate value, or AND, OR or XOR an immediate into the register. Reading the register for a store uses the `ccr_o` output. A separate one-bit write lets bit-manipulation logic use the carry flag as an accumulator.

An exception-entry strobe forces the interrupt mask bit to 1. The block also gates a maskable interrupt request against the mask bits and lets a non-maskable request through unconditionally.

Top module: `flagreg_core`

## Requirements
- R1: The register bits from bit 7 down to bit 0 are I, UI, H, U, N, Z, V, C. A synchronous reset sets the register to 8'h80, which is I=1 and every other bit 0.
- R2: `alu_op` selects the operation: 00 add (A+B), 01 subtract (A-B), 10 compare (A-B, same flags as subtract), 11 negate (0-A). `size` selects the width: 00 byte (bits 7:0), 01 word (bits 15:0), 10 and 11 longword (bits 31:0). Operand bits above the selected width are ignored. H is the carry, or for the subtracting operations the borrow, out of bit 3 for byte, bit 11 for word and bit 27 for longword.
- R3: C is the carry out of the most significant bit of the selected width for add, and the borrow for subtract, compare and negate.
- R4: N equals the most significant bit of the sized result. Z is 1 only when every bit of the sized result is 0.
- R5: V is 1 exactly when the signed result at the selected width overflows, and 0 otherwise.
- R6: When `upd_en` is 0, the arithmetic leaves H, N, Z, V and C unchanged.
- R7: `sw_op` codes the software command: 000 none, 001 load `sw_imm`, 010 AND, 011 OR, 100 XOR with `sw_imm`. Codes 101 to 111 do nothing. A software command sets all 8 bits and overrides any arithmetic or carry write in the same cycle.
- R8: When `bit_we` is 1 and no software command is active, C takes `bit_c`. This overrides the arithmetic carry in the same cycle.
- R9: `exc_entry` forces I to 1 on the next edge, even when a software command in the same cycle writes I as 0. All other bits follow their normal update.
- R10: `irq_take` = `nmi_req` OR (`irq_req` AND NOT I AND NOT UI), evaluated against the current register. This is combinational.
- R11: UI and U change only through reset or a software command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| alu_op | input | 2 | Arithmetic operation code |
| size | input | 2 | Operand size select |
| upd_en | input | 1 | Apply the arithmetic flags this cycle |
| sw_op | input | 3 | Software register command |
| sw_imm | input | 8 | Immediate for the software command |
| bit_we | input | 1 | Carry accumulator write strobe |
| bit_c | input | 1 | Carry accumulator write value |
| exc_entry | input | 1 | Exception entry strobe |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ccr_o | output | 8 | Current register value |
| irq_take | output | 1 | Interrupt accepted |

## Verification
Directed operands sit exactly on each size's nibble boundary (bit 3, 11 or 27) and on the sign boundary. This separates the half-carry tap from the carry tap, and a correct signed overflow from a plain sign change. Operands with nonzero upper bits at byte and word size show whether the size masking holds. Random cycles mix every operation, size, software command (reserved codes included), carry write and exception strobe. These random cycles exercise the write priorities and the interrupt gate against a bench model of the register.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;

    localparam int DATA_W = 32;
    localparam int CCR_W  = 8;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int NIB_W  = 4;

    localparam logic [1:0] OP_ADD = 2'b00;
    localparam logic [1:0] OP_SUB = 2'b01;
    localparam logic [1:0] OP_CMP = 2'b10;
    localparam logic [1:0] OP_NEG = 2'b11;

    localparam logic [2:0] SW_NONE = 3'd0;
    localparam logic [2:0] SW_LOAD = 3'd1;
    localparam logic [2:0] SW_AND  = 3'd2;
    localparam logic [2:0] SW_OR   = 3'd3;
    localparam logic [2:0] SW_XOR  = 3'd4;

    localparam logic [CCR_W-1:0] CCR_RESET = 8'h80;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef struct packed {
        logic imask;
        logic umask;
        logic half;
        logic user;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

    typedef struct packed {
        logic half;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } arith_flags_t;

    // Low-ones mask covering the active operand width.
    function automatic logic [DATA_W-1:0] width_mask(input size_e sz);
        case (sz)
            SZ_BYTE: width_mask = {DATA_W{1'b1}} >> (DATA_W - BYTE_W);
            SZ_WORD: width_mask = {DATA_W{1'b1}} >> (DATA_W - WORD_W);
            default: width_mask = {DATA_W{1'b1}};
        endcase
    endfunction

    // Bits below the half-carry tap: one nibble short of the width.
    function automatic logic [DATA_W-1:0] half_mask(input size_e sz);
        half_mask = width_mask(sz) >> NIB_W;
    endfunction

    // One-hot position of the sign bit at the active width.
    function automatic logic [DATA_W-1:0] sign_onehot(input size_e sz);
        sign_onehot = width_mask(sz) ^ (width_mask(sz) >> 1);
    endfunction

endpackage

// File: rtl/flagreg_arith.sv
module flagreg_arith
    import flagreg_pkg::*;
(
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        size_i,
    output arith_flags_t      flags_o
);

    localparam logic [DATA_W:0] ONE_EXT = {{DATA_W{1'b0}}, 1'b1};

    logic [DATA_W-1:0] wmask, hmask, sbit;
    logic [DATA_W-1:0] x, y, res;
    logic [DATA_W:0]   full, hfull, cpos, hpos;
    logic              is_sub, sx, sy, sr;

    always_comb begin
        wmask  = width_mask(size_e'(size_i));
        hmask  = half_mask(size_e'(size_i));
        sbit   = sign_onehot(size_e'(size_i));
        is_sub = (op_i != OP_ADD);

        if (op_i == OP_NEG) begin
            x = '0;
            y = opa_i & wmask;
        end else begin
            x = opa_i & wmask;
            y = opb_i & wmask;
        end

        // Unsigned extension by one bit exposes carry/borrow at the tap.
        if (is_sub) begin
            full  = {1'b0, x} - {1'b0, y};
            hfull = {1'b0, x & hmask} - {1'b0, y & hmask};
        end else begin
            full  = {1'b0, x} + {1'b0, y};
            hfull = {1'b0, x & hmask} + {1'b0, y & hmask};
        end

        cpos = {sbit, 1'b0};
        hpos = {1'b0, hmask} + ONE_EXT;
        res  = full[DATA_W-1:0] & wmask;

        sx = |(x & sbit);
        sy = |(y & sbit);
        sr = |(res & sbit);

        flags_o.half  = |(hfull & hpos);
        flags_o.carry = |(full & cpos);
        flags_o.neg   = sr;
        flags_o.zero  = (res == '0);
        if (is_sub)
            flags_o.ovf = (sx != sy) && (sr != sx);
        else
            flags_o.ovf = (sx == sy) && (sr != sx);
    end

endmodule

// File: rtl/flagreg_next.sv
module flagreg_next
    import flagreg_pkg::*;
(
    input  ccr_t             cur_i,
    input  arith_flags_t     flags_i,
    input  logic             upd_en_i,
    input  logic [2:0]       sw_op_i,
    input  logic [CCR_W-1:0] sw_imm_i,
    input  logic             bit_we_i,
    input  logic             bit_c_i,
    input  logic             exc_i,
    output ccr_t             nxt_o
);

    always_comb begin
        nxt_o = cur_i;

        if (upd_en_i) begin
            nxt_o.half  = flags_i.half;
            nxt_o.neg   = flags_i.neg;
            nxt_o.zero  = flags_i.zero;
            nxt_o.ovf   = flags_i.ovf;
            nxt_o.carry = flags_i.carry;
        end

        if (bit_we_i)
            nxt_o.carry = bit_c_i;

        case (sw_op_i)
            SW_LOAD: nxt_o = ccr_t'(sw_imm_i);
            SW_AND:  nxt_o = ccr_t'(cur_i & sw_imm_i);
            SW_OR:   nxt_o = ccr_t'(cur_i | sw_imm_i);
            SW_XOR:  nxt_o = ccr_t'(cur_i ^ sw_imm_i);
            default: ;
        endcase

        if (exc_i)
            nxt_o.imask = 1'b1;
    end

endmodule

// File: rtl/flagreg_irq_gate.sv
module flagreg_irq_gate
    import flagreg_pkg::*;
#(
    parameter bit UI_IS_MASK = 1'b1
) (
    input  ccr_t ccr_i,
    input  logic irq_i,
    input  logic nmi_i,
    output logic take_o
);

    logic masked;

    generate
        if (UI_IS_MASK) begin : g_two_masks
            assign masked = ccr_i.imask | ccr_i.umask;
        end else begin : g_one_mask
            assign masked = ccr_i.imask;
        end
    endgenerate

    assign take_o = nmi_i | (irq_i & ~masked);

endmodule

// File: rtl/flagreg_core.sv
module flagreg_core
    import flagreg_pkg::*;
#(
    parameter bit UI_IS_MASK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        alu_op,
    input  logic [1:0]        size,
    input  logic              upd_en,
    input  logic [2:0]        sw_op,
    input  logic [CCR_W-1:0]  sw_imm,
    input  logic              bit_we,
    input  logic              bit_c,
    input  logic              exc_entry,
    input  logic              irq_req,
    input  logic              nmi_req,
    output logic [CCR_W-1:0]  ccr_o,
    output logic              irq_take
);

    ccr_t         ccr_q, ccr_d;
    arith_flags_t aflags;

    flagreg_arith u_arith (
        .opa_i   (opa),
        .opb_i   (opb),
        .op_i    (alu_op),
        .size_i  (size),
        .flags_o (aflags)
    );

    flagreg_next u_next (
        .cur_i    (ccr_q),
        .flags_i  (aflags),
        .upd_en_i (upd_en),
        .sw_op_i  (sw_op),
        .sw_imm_i (sw_imm),
        .bit_we_i (bit_we),
        .bit_c_i  (bit_c),
        .exc_i    (exc_entry),
        .nxt_o    (ccr_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ccr_q <= ccr_t'(CCR_RESET);
        else
            ccr_q <= ccr_d;
    end

    flagreg_irq_gate #(.UI_IS_MASK(UI_IS_MASK)) u_gate (
        .ccr_i  (ccr_q),
        .irq_i  (irq_req),
        .nmi_i  (nmi_req),
        .take_o (irq_take)
    );

    assign ccr_o = ccr_q;

endmodule

// File: rtl/flagreg_checker.sv
module flagreg_checker (
    input logic       clk,
    input logic       rst,
    input logic       upd_en,
    input logic [2:0] sw_op,
    input logic       bit_we,
    input logic       exc_entry,
    input logic       irq_req,
    input logic       nmi_req,
    input logic [7:0] ccr_o,
    input logic       irq_take
);

    logic sw_active;
    assign sw_active = (sw_op != 3'd0) && (sw_op <= 3'd4);

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ccr_o == 8'h80);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !sw_active && !bit_we && !exc_entry) |=> $stable(ccr_o));

    assert_exc_sets_i_R9: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> ccr_o[7]);

    assert_nmi_always_taken_R10: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> irq_take);

    assert_i_blocks_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (ccr_o[7] && !nmi_req) |-> !irq_take);

    assert_user_bits_sw_only_R11: assert property (@(posedge clk) disable iff (rst)
        !sw_active |=> (ccr_o[6] == $past(ccr_o[6])) && (ccr_o[4] == $past(ccr_o[4])));

endmodule

bind flagreg_core flagreg_checker u_flagreg_checker (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .sw_op     (sw_op),
    .bit_we    (bit_we),
    .exc_entry (exc_entry),
    .irq_req   (irq_req),
    .nmi_req   (nmi_req),
    .ccr_o     (ccr_o),
    .irq_take  (irq_take)
);

// File: tb/test_flagreg_core.sv
module test_flagreg_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa = '0, opb = '0;
    logic [1:0]  alu_op = '0, size = '0;
    logic        upd_en = 1'b0;
    logic [2:0]  sw_op = '0;
    logic [7:0]  sw_imm = '0;
    logic        bit_we = 1'b0, bit_c = 1'b0;
    logic        exc_entry = 1'b0, irq_req = 1'b0, nmi_req = 1'b0;
    logic [7:0]  ccr_o;
    logic        irq_take;

    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;
    logic [7:0] model = 8'h80;

    always #2.5 clk = ~clk;

    flagreg_core i_flagreg_core (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .alu_op(alu_op), .size(size),
        .upd_en(upd_en), .sw_op(sw_op), .sw_imm(sw_imm), .bit_we(bit_we), .bit_c(bit_c),
        .exc_entry(exc_entry), .irq_req(irq_req), .nmi_req(nmi_req),
        .ccr_o(ccr_o), .irq_take(irq_take)
    );

    // {H,N,Z,V,C} from the requirement definitions, using signed integers.
    function automatic logic [4:0] ref_flags(input logic [1:0] op, input logic [1:0] sz,
                                             input logic [31:0] a, input logic [31:0] b);
        int w, hw;
        longint unsigned m, hm, x, y, r, hr;
        longint sx, sy, s, hi, lo;
        logic v;
        w  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        hw = w - 4;
        m  = (64'd1 << w) - 1;
        hm = (64'd1 << hw) - 1;
        x  = (op == 2'b11) ? 64'd0 : (longint'(a) & m);
        y  = (op == 2'b11) ? (longint'(a) & m) : (longint'(b) & m);
        if (op == 2'b00) begin
            r  = x + y;
            hr = (x & hm) + (y & hm);
        end else begin
            r  = x - y;
            hr = (x & hm) - (y & hm);
        end
        sx = longint'(x);
        if (x[w-1]) sx = sx - longint'(64'd1 << w);
        sy = longint'(y);
        if (y[w-1]) sy = sy - longint'(64'd1 << w);
        s  = (op == 2'b00) ? (sx + sy) : (sx - sy);
        hi = longint'(64'd1 << (w - 1)) - 1;
        lo = -hi - 1;
        v  = (s > hi) || (s < lo);
        return {hr[hw], r[w-1], ((r & m) == 64'd0), v, r[w]};
    endfunction

    function automatic logic [7:0] ref_next(input logic [7:0] cur);
        logic [7:0] n;
        logic [4:0] f;
        n = cur;
        f = ref_flags(alu_op, size, opa, opb);
        if (upd_en) begin
            n[5] = f[4]; n[3] = f[3]; n[2] = f[2]; n[1] = f[1]; n[0] = f[0];
        end
        if (bit_we) n[0] = bit_c;
        case (sw_op)
            3'd1: n = sw_imm;
            3'd2: n = cur & sw_imm;
            3'd3: n = cur | sw_imm;
            3'd4: n = cur ^ sw_imm;
            default: ;
        endcase
        if (exc_entry) n[7] = 1'b1;
        return n;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [7:0] nxt;
        nxt = ref_next(model);
        @(posedge clk);
        #1;
        model = nxt;
        check({tag, " ccr"}, {24'd0, ccr_o}, {24'd0, model});
        check("R10 irq_take", {31'd0, irq_take},
              {31'd0, nmi_req | (irq_req & ~model[7] & ~model[6])});
    endtask

    task automatic arith(input string tag, input logic [1:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        alu_op = op; size = sz; opa = a; opb = b; upd_en = 1'b1;
        sw_op = 3'd0; bit_we = 1'b0; exc_entry = 1'b0;
        step(tag);
    endtask

    task automatic swcmd(input string tag, input logic [2:0] code, input logic [7:0] imm);
        @(negedge clk);
        upd_en = 1'b0; sw_op = code; sw_imm = imm; bit_we = 1'b0; exc_entry = 1'b0;
        step(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value", {24'd0, ccr_o}, 32'h80);
        @(negedge clk);
        rst = 1'b0; irq_req = 1'b1;
        step("R1 after reset");
        check("R10 masked by I after reset", {31'd0, irq_take}, 32'd0);

        swcmd("R7 load clears", 3'd1, 8'h00);
        check("R10 irq accepted when unmasked", {31'd0, irq_take}, 32'd1);

        arith("R2 byte half carry", 2'b00, 2'b00, 32'h0000_000F, 32'h0000_0001);
        check("R2 byte H", {31'd0, ccr_o[5]}, 32'd1);
        arith("R2 word half carry", 2'b00, 2'b01, 32'hABCD_0FFF, 32'h0000_0001);
        check("R2 word H", {31'd0, ccr_o[5]}, 32'd1);
        arith("R2 long half carry", 2'b00, 2'b10, 32'h0FFF_FFFF, 32'h0000_0001);
        check("R2 long H", {31'd0, ccr_o[5]}, 32'd1);
        arith("R5 byte overflow", 2'b00, 2'b00, 32'h1234_567F, 32'h0000_0001);
        check("R5 V and N", {30'd0, ccr_o[3], ccr_o[1]}, 32'd3);
        arith("R3 byte carry zero", 2'b00, 2'b00, 32'h1234_56FF, 32'hFF00_0001);
        check("R3 C and R4 Z", {30'd0, ccr_o[2], ccr_o[0]}, 32'd3);
        arith("R3 sub borrow", 2'b01, 2'b01, 32'h0000_0000, 32'h0000_0001);
        check("R3 borrow C", {31'd0, ccr_o[0]}, 32'd1);
        arith("R4 cmp equal", 2'b10, 2'b10, 32'h8000_0000, 32'h8000_0000);
        check("R4 Z", {31'd0, ccr_o[2]}, 32'd1);
        arith("R5 neg min long", 2'b11, 2'b10, 32'h8000_0000, 32'h0);
        check("R5 neg V", {31'd0, ccr_o[1]}, 32'd1);
        arith("R2 size 11 as long", 2'b00, 2'b11, 32'h0FFF_FFFF, 32'h1);

        @(negedge clk);
        upd_en = 1'b0; opa = 32'hFF; opb = 32'h1; alu_op = 2'b00; size = 2'b00;
        step("R6 no update");
        swcmd("R7 load 55", 3'd1, 8'h55);
        swcmd("R7 and", 3'd2, 8'h0F);
        swcmd("R7 or", 3'd3, 8'hA0);
        swcmd("R7 xor", 3'd4, 8'hFF);
        swcmd("R7 reserved code ignored", 3'd6, 8'h00);
        check("R7 reserved keeps value", {24'd0, ccr_o}, 32'h5A);

        @(negedge clk);
        upd_en = 1'b1; alu_op = 2'b01; size = 2'b00; opa = 0; opb = 1;
        sw_op = 3'd1; sw_imm = 8'h12;
        step("R7 software over arith");
        check("R7 loaded value", {24'd0, ccr_o}, 32'h12);

        @(negedge clk);
        sw_op = 3'd0; bit_we = 1'b1; bit_c = 1'b0; upd_en = 1'b1;
        opa = 32'hFF; opb = 32'h1;
        step("R8 bit write over carry");
        check("R8 C from bit", {31'd0, ccr_o[0]}, 32'd0);

        @(negedge clk);
        bit_we = 1'b0; upd_en = 1'b0; sw_op = 3'd1; sw_imm = 8'h00; exc_entry = 1'b1;
        step("R9 exception wins");
        check("R9 I set", {31'd0, ccr_o[7]}, 32'd1);

        swcmd("R11 load UI", 3'd1, 8'h40);
        @(negedge clk);
        sw_op = 3'd0; irq_req = 1'b1; nmi_req = 1'b0;
        step("R10 UI masks");
        check("R10 UI masked", {31'd0, irq_take}, 32'd0);
        @(negedge clk);
        nmi_req = 1'b1;
        step("R10 nmi passes");
        check("R10 nmi", {31'd0, irq_take}, 32'd1);

        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            alu_op    = 2'($urandom_range(0, 3));
            size      = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 3))
                0: opa = 32'h7F7F_7F7F;
                1: opa = 32'h8000_8080;
                default: opa = $urandom;
            endcase
            opb       = ($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            upd_en    = ($urandom_range(0, 9) < 7);
            sw_op     = ($urandom_range(0, 9) < 7) ? 3'd0 : 3'($urandom_range(1, 7));
            sw_imm    = 8'($urandom);
            bit_we    = ($urandom_range(0, 4) == 0);
            bit_c     = 1'($urandom);
            exc_entry = ($urandom_range(0, 9) == 0);
            irq_req   = 1'($urandom);
            nmi_req   = ($urandom_range(0, 7) == 0);
            step("R3/R11 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule